// File: doc/BRIEF.md
# Memory write protection controller

This block sits beside the storage of a serial nonvolatile memory and decides, one request at a time, whether a write may go ahead. It owns the status byte, which holds the write-enable latch, a two-bit protection zone, a selector that redirects memory writes to a separate 256-byte identification page, a one-time lock for that page, and a protect-enable bit that works together with an active-low hardware protect pin.

The surrounding protocol logic presents a request with a kind, a target address and, for status writes, the new status byte. In the same cycle the block raises `allow` when the write is permitted. The status byte updates on the following clock edge and is always readable on `status_q`. The serial protocol and the memory array are outside this block.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset `status_q` is 8'h00 and `allow` is low.
- R2: Request kind 0 sets the write-enable latch and kind 1 clears it. The latch is visible at `status_q[1]` from the next cycle. Neither kind raises `allow`.
- R3: A status write (kind 2) or a memory write (kind 3) is never allowed while the write-enable latch is 0.
- R4: Every status or memory write request clears the write-enable latch at the next edge, whether it was allowed or refused.
- R5: A status write is refused while `hw_wp_n` is 0 and the protect-enable bit `status_q[7]` is 1. When `hw_wp_n` is 1, the pin blocks nothing.
- R6: The zone field `status_q[3:2]` guards the main array by comparing against the two top address bits. 00 guards nothing. 01 guards addresses whose top bits are 11. 10 guards addresses whose top bit is 1. 11 guards every address. A memory write to a guarded address is refused.
- R7: While the page selector `status_q[4]` is 1, a memory write targets the identification page. The zone field is then ignored, and the write is allowed exactly when the latch is set and the lock is clear.
- R8: The lock bit `status_q[5]` is set by an allowed status write whose bit 5 is 1. Once set, it stays 1 until reset, and later status writes cannot clear it.
- R9: An allowed status write loads `req_wdata` bits 7, 4 and 3:2 into the protect-enable, page-select and zone fields. A refused one leaves `status_q[7:2]` unchanged.
- R10: `status_q` bits 6 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wp_n | input | 1 | Hardware protect pin, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 0 latch set, 1 latch clear, 2 status write, 3 memory write |
| req_addr | input | ADDR_W | Target address of a memory write |
| req_wdata | input | 8 | New status byte for a status write |
| allow | output | 1 | The presented write is permitted (same cycle) |
| status_q | output | 8 | Readable status byte |

## Verification
The bench builds the block with ADDR_W = 6. With that width, every address of the main array can be tried under each of the four zone codes, so each boundary between guarded and open addresses is visited exactly. The small width also gives a long random request stream a dense mix of pin levels, page selection and lock transitions. Those random runs reach states such as a locked page under an active pin, which directed cases rarely produce. A behavioural model compares `allow` and `status_q` on every cycle.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

   typedef enum logic [1:0] {
      K_LATCH_SET = 2'd0,
      K_LATCH_CLR = 2'd1,
      K_STAT_WR   = 2'd2,
      K_MEM_WR    = 2'd3
   } req_kind_e;

   localparam int ST_W      = 8;
   localparam int B_LATCH   = 1;
   localparam int B_ZONE_LO = 2;
   localparam int B_IDSEL   = 4;
   localparam int B_LOCK    = 5;
   localparam int B_PROT_EN = 7;

   typedef struct packed {
      logic       prot_en;
      logic       id_lock;
      logic       id_sel;
      logic [1:0] zone;
      logic       latch;
   } wp_state_t;

   function automatic logic [ST_W-1:0] pack_status(input wp_state_t s);
      logic [ST_W-1:0] b;
      b = '0;
      b[B_PROT_EN]               = s.prot_en;
      b[B_LOCK]                  = s.id_lock;
      b[B_IDSEL]                 = s.id_sel;
      b[B_ZONE_LO+1:B_ZONE_LO]   = s.zone;
      b[B_LATCH]                 = s.latch;
      return b;
   endfunction

endpackage

// File: rtl/wprot_region.sv
module wprot_region #(
   parameter int ADDR_W = 18
) (
   input  logic [1:0]        zone,
   input  logic [ADDR_W-1:0] addr,
   output logic              guarded
);
   localparam int TOP_HI = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("wprot_region: ADDR_W must be at least 2");
      end
      if (ADDR_W > 2) begin : g_low_bits
         logic unused_lo;
         assign unused_lo = ^addr[ADDR_W-3:0];
      end
   endgenerate

   logic [1:0] top2;
   assign top2 = addr[TOP_HI -: 2];

   always_comb begin
      unique case (zone)
         2'b00:   guarded = 1'b0;
         2'b01:   guarded = (top2 == 2'b11);
         2'b10:   guarded = top2[1];
         default: guarded = 1'b1;
      endcase
   end

endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
   import wprot_pkg::*;
(
   input  wp_state_t  st,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   input  logic       hw_wp_n,
   input  logic       guarded,
   output logic       allow,
   output logic       set_latch,
   output logic       clr_latch,
   output logic       stat_load
);
   logic is_stat, is_mem, stat_ok, mem_ok;

   assign is_stat = req_valid && (req_kind == K_STAT_WR);
   assign is_mem  = req_valid && (req_kind == K_MEM_WR);

   assign stat_ok = st.latch && !(!hw_wp_n && st.prot_en);
   assign mem_ok  = st.latch && (st.id_sel ? !st.id_lock : !guarded);

   assign allow     = (is_stat && stat_ok) || (is_mem && mem_ok);
   assign stat_load = is_stat && stat_ok;
   assign set_latch = req_valid && (req_kind == K_LATCH_SET);
   assign clr_latch = is_stat || is_mem || (req_valid && (req_kind == K_LATCH_CLR));

endmodule

// File: rtl/wprot_state.sv
module wprot_state
   import wprot_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_latch,
   input  logic            clr_latch,
   input  logic            stat_load,
   input  logic [ST_W-1:0] stat_data,
   output wp_state_t       st
);
   logic unused_bits;
   assign unused_bits = ^{stat_data[6], stat_data[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         if (clr_latch)      st.latch <= 1'b0;
         else if (set_latch) st.latch <= 1'b1;
         if (stat_load) begin
            st.prot_en <= stat_data[B_PROT_EN];
            st.id_sel  <= stat_data[B_IDSEL];
            st.zone    <= stat_data[B_ZONE_LO+1:B_ZONE_LO];
            st.id_lock <= st.id_lock | stat_data[B_LOCK];
         end
      end
   end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
   import wprot_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_wp_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   output logic              allow,
   output logic [7:0]        status_q
);
   wp_state_t st;
   logic guarded, set_latch, clr_latch, stat_load;

   wprot_region #(.ADDR_W(ADDR_W)) u_region (
      .zone    (st.zone),
      .addr    (req_addr),
      .guarded (guarded)
   );

   wprot_decide u_decide (
      .st        (st),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .hw_wp_n   (hw_wp_n),
      .guarded   (guarded),
      .allow     (allow),
      .set_latch (set_latch),
      .clr_latch (clr_latch),
      .stat_load (stat_load)
   );

   wprot_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_latch (set_latch),
      .clr_latch (clr_latch),
      .stat_load (stat_load),
      .stat_data (req_wdata),
      .st        (st)
   );

   assign status_q = pack_status(st);

   a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == K_LATCH_SET) |=> status_q[B_LATCH]);
   a_r3_need_latch: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> status_q[B_LATCH]);
   a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind[1]) |=> !status_q[B_LATCH]);
   a_r5_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == K_STAT_WR && !hw_wp_n && status_q[B_PROT_EN]) |-> !allow);
   a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[B_LOCK] |=> status_q[B_LOCK]);
   a_r9_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == K_STAT_WR && !allow) |=> $stable(status_q[7:2]));
   a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !status_q[6] && !status_q[0]);

endmodule

// File: tb/sim_wprot_ctrl.sv
`timescale 1ns/1ps
module sim_wprot_ctrl;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hw_wp_n = 1'b1;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic allow;
   logic [7:0] status_q;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // behavioural model state
   int m_wel = 0, m_zone = 0, m_ids = 0, m_lock = 0, m_pe = 0;

   always #2.5 clk = ~clk;

   wprot_ctrl #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .hw_wp_n(hw_wp_n), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .allow(allow), .status_q(status_q)
   );

   function automatic int exp_status();
      return (m_pe << 7) | (m_lock << 5) | (m_ids << 4) | (m_zone << 2) | (m_wel << 1);
   endfunction

   function automatic int zone_hit(int a);
      int top;
      top = a >> (AW - 2);
      if (m_zone == 3) return 1;
      if (m_zone == 2) return (top >= 2) ? 1 : 0;
      if (m_zone == 1) return (top == 3) ? 1 : 0;
      return 0;
   endfunction

   function automatic int exp_allow(int v, int k, int a, int wp);
      if (!v || m_wel == 0) return 0;
      if (k == 2) return (wp == 0 && m_pe == 1) ? 0 : 1;
      if (k == 3) return m_ids ? (m_lock ? 0 : 1) : (zone_hit(a) ? 0 : 1);
      return 0;
   endfunction

   task automatic check(string tag, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(string tag, int v, int k, int a, int d, int wp);
      int ea;
      @(negedge clk);
      req_valid = v[0]; req_kind = k[1:0]; req_addr = a[AW-1:0];
      req_wdata = d[7:0]; hw_wp_n = wp[0];
      #1;
      ea = exp_allow(v, k, a, wp);
      check({tag, " allow"}, int'(allow), ea);
      check({tag, " status"}, int'(status_q), exp_status());
      @(posedge clk);
      if (v) begin
         case (k)
            0: m_wel = 1;
            1: m_wel = 0;
            2: begin
               if (ea) begin
                  m_pe = (d >> 7) & 1; m_ids = (d >> 4) & 1;
                  m_zone = (d >> 2) & 3; m_lock = m_lock | ((d >> 5) & 1);
               end
               m_wel = 0;
            end
            default: m_wel = 0;
         endcase
      end
   endtask

   task automatic wr_status(string tag, int d, int wp);
      step(tag, 1, 0, 0, 0, wp);
      step(tag, 1, 2, 0, d, wp);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      step("R1", 0, 0, 0, 0, 1);
      // R2 latch set/clear, no allow
      step("R2", 1, 0, 0, 0, 1);
      step("R2", 1, 1, 0, 0, 1);
      step("R2", 0, 0, 0, 0, 1);
      // R3 writes without latch refused
      step("R3", 1, 3, 0, 0, 1);
      step("R3", 1, 2, 0, 8'h0c, 1);
      // R4 allowed mem write clears latch
      step("R4", 1, 0, 0, 0, 1);
      step("R4", 1, 3, 5, 0, 1);
      step("R4", 0, 0, 0, 0, 1);
      // R6 exhaustive address sweep per zone
      for (int z = 0; z < 4; z++) begin
         wr_status("R6", z << 2, 1);
         for (int a = 0; a < (1 << AW); a++) begin
            step("R6", 1, 0, 0, 0, 1);
            step("R6", 1, 3, a, 0, 1);
         end
      end
      // R4 refused mem write still clears latch (zone 11 active)
      step("R4", 1, 0, 0, 0, 1);
      step("R4", 1, 3, 1, 0, 1);
      step("R4", 0, 0, 0, 0, 1);
      // R5 pin high does not block even with protect-enable
      wr_status("R5", 8'h84, 1);
      wr_status("R5", 8'h88, 1);
      // R9 refused status write leaves fields, R5 pin low blocks
      wr_status("R9", 8'h00, 0);
      step("R9", 0, 0, 0, 0, 0);
      wr_status("R10", 8'h41, 1);
      // R7 id page: zone ignored
      wr_status("R7", 8'h1c, 1);
      step("R7", 1, 0, 0, 0, 1);
      step("R7", 1, 3, 63, 0, 1);
      // R8 lock and stickiness
      wr_status("R8", 8'h30, 1);
      step("R8", 1, 0, 0, 0, 1);
      step("R8", 1, 3, 2, 0, 1);
      wr_status("R8", 8'h00, 1);
      step("R8", 0, 0, 0, 0, 1);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int k, a, d, w, v;
         v = ($urandom % 8) != 0;
         k = $urandom % 4; a = $urandom % (1 << AW);
         d = $urandom % 256; w = ($urandom % 3) != 0;
         if (k == 2 && ($urandom % 4) != 0) d = d & 8'hdf;
         step("R3 R6 R7 random", v, k, a, d, w);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule